// File: doc/BRIEF.md
# Bidirectional GPIO Port Controller

This block controls a bank of general-purpose pins (eight by default) behind a simple register bus. Each pin has three bits: a direction bit, a drive/pull bit and a sampled input level. Each kind of bit has its own register, with its own write strobe and its own read strobe. All pins of the bank share these strobes. The block drives each pad's output enable and output value. It raises a pull-up request for undriven pins and returns the pin levels after a two-flop synchronizer.

Two inputs are shared by every bank on the chip. The first is a global pull-up disable, which suppresses every pull-up request. The second is a sleep signal, which forces 0 into the synchronizer so that floating pads cannot toggle it. Software flips output bits by writing ones to the input-register address. This needs no read-modify-write of the drive register. Reads are combinational, and the read bus is 0 whenever no read strobe is active.

Top module: `gpio_port_ctl`

## Requirements
- R1: After reset, every direction bit and drive bit is 0. So `padOe` and `padOut` are all 0, and a read of the input register returns 0 until pad levels have been sampled.
- R2: A write with `wrDir` loads `wrData` into the direction bits at the clock edge. A 1 makes that pin an output (`padOe` bit = 1), and a 0 makes it an input.
- R3: A write with `wrOut` loads `wrData` into the drive bits at the clock edge. They appear on `padOut` and read back through `rdOut`.
- R4: A write with `wrPin` inverts every drive bit whose `wrData` bit is 1 and leaves the bits whose `wrData` bit is 0 unchanged.
- R5: If `wrOut` and `wrPin` are both active in the same cycle, the `wrOut` load wins and no toggle is applied.
- R6: `pullReq[i]` is 1 exactly when pin i is an input, its drive bit is 1 and `pullupDis` is 0.
- R7: A `rdPin` read returns the pad level from two clock edges earlier. A level presented before a single edge is not yet visible.
- R8: While `sleep` is 1, the synchronizer samples 0, so a `rdPin` read two edges into sleep returns 0. After `sleep` returns to 0, the real pad levels reappear two edges later.
- R9: Reads are combinational in the cycle of the strobe: `rdDir` returns the direction bits, `rdOut` returns the drive bits and `rdPin` returns the synchronized levels. With no read strobe, `rdData` is 0. With several read strobes, `rdData` is the bitwise OR of the selected registers.
- R10: A register changes only on its own write strobe. A direction write leaves the drive bits unchanged, and a drive or toggle write leaves the direction bits unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | I/O clock |
| rstN | input | 1 | Active-low asynchronous reset |
| wrDir | input | 1 | Write strobe, direction register |
| wrOut | input | 1 | Write strobe, drive register |
| wrPin | input | 1 | Write strobe, input-register address (toggles drive bits) |
| rdDir | input | 1 | Read strobe, direction register |
| rdOut | input | 1 | Read strobe, drive register |
| rdPin | input | 1 | Read strobe, synchronized pin levels |
| wrData | input | NUM_PINS | Write data |
| rdData | output | NUM_PINS | Read data, 0 when no read strobe |
| pullupDis | input | 1 | Global pull-up disable |
| sleep | input | 1 | Global sleep, gates the synchronizer input |
| padIn | input | NUM_PINS | Pad levels (asynchronous) |
| padOe | output | NUM_PINS | Pad output enables |
| padOut | output | NUM_PINS | Pad output values |
| pullReq | output | NUM_PINS | Pull-up requests |

## Verification
The hardest case to reach from the ports is the synchronizer's latency window. A level must be shown to be absent after one edge and present after two. A sleep change must also be shown to take effect through the same pipeline. The bench holds a pad pattern for at least two edges and then changes it. It reads once after a single edge and expects the old pattern, then reads after the second edge and expects the new one. It repeats this with sleep raised and then lowered. The same-cycle collision of a drive write with a toggle write is also forced directly, because random strobe timing would seldom produce it.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  typedef struct packed {
    logic loadDir;
    logic loadOut;
    logic togOut;
    logic selDir;
    logic selOut;
    logic selPin;
  } gpioStrobe_t;
endpackage

// File: rtl/gpio_ctrl.sv
module gpio_ctrl
  import gpio_pkg::*;
(
  input  logic        wrDir,
  input  logic        wrOut,
  input  logic        wrPin,
  input  logic        rdDir,
  input  logic        rdOut,
  input  logic        rdPin,
  output gpioStrobe_t strobe
);
  always_comb begin
    strobe.loadDir = wrDir;
    strobe.loadOut = wrOut;
    // a load of the drive register takes precedence over a toggle
    strobe.togOut  = wrPin & ~wrOut;
    strobe.selDir  = rdDir;
    strobe.selOut  = rdOut;
    strobe.selPin  = rdPin;
  end
endmodule

// File: rtl/gpio_dpath.sv
module gpio_dpath
  import gpio_pkg::*;
#(
  parameter int NUM_PINS   = 8,
  parameter int SYNC_DEPTH = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  gpioStrobe_t         strobe,
  input  logic [NUM_PINS-1:0] wrData,
  output logic [NUM_PINS-1:0] rdData,
  input  logic                pullupDis,
  input  logic                sleep,
  input  logic [NUM_PINS-1:0] padIn,
  output logic [NUM_PINS-1:0] padOe,
  output logic [NUM_PINS-1:0] padOut,
  output logic [NUM_PINS-1:0] pullReq
);
  localparam int LAST = SYNC_DEPTH - 1;

  logic [NUM_PINS-1:0] dirReg;
  logic [NUM_PINS-1:0] outReg;
  logic [NUM_PINS-1:0] syncStage [SYNC_DEPTH];
  logic [NUM_PINS-1:0] gatedIn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) dirReg <= '0;
    else if (strobe.loadDir) dirReg <= wrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) outReg <= '0;
    else if (strobe.loadOut) outReg <= wrData;
    else if (strobe.togOut) outReg <= outReg ^ wrData;
  end

  assign gatedIn = sleep ? '0 : padIn;

  genvar s;
  generate
    for (s = 0; s < SYNC_DEPTH; s++) begin : g_sync
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncStage[s] <= '0;
        else if (s == 0) syncStage[s] <= gatedIn;
        else syncStage[s] <= syncStage[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  genvar p;
  generate
    for (p = 0; p < NUM_PINS; p++) begin : g_pin
      assign pullReq[p] = ~dirReg[p] & outReg[p] & ~pullupDis;
    end
  endgenerate

  assign padOe  = dirReg;
  assign padOut = outReg;

  always_comb begin
    rdData = '0;
    if (strobe.selDir) rdData = rdData | dirReg;
    if (strobe.selOut) rdData = rdData | outReg;
    if (strobe.selPin) rdData = rdData | syncStage[LAST];
  end
endmodule

// File: rtl/gpio_port_ctl.sv
module gpio_port_ctl
  import gpio_pkg::*;
#(
  parameter int NUM_PINS = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                wrDir,
  input  logic                wrOut,
  input  logic                wrPin,
  input  logic                rdDir,
  input  logic                rdOut,
  input  logic                rdPin,
  input  logic [NUM_PINS-1:0] wrData,
  output logic [NUM_PINS-1:0] rdData,
  input  logic                pullupDis,
  input  logic                sleep,
  input  logic [NUM_PINS-1:0] padIn,
  output logic [NUM_PINS-1:0] padOe,
  output logic [NUM_PINS-1:0] padOut,
  output logic [NUM_PINS-1:0] pullReq
);
  gpioStrobe_t strobe;

  gpio_ctrl i_ctrl (
    .wrDir(wrDir), .wrOut(wrOut), .wrPin(wrPin),
    .rdDir(rdDir), .rdOut(rdOut), .rdPin(rdPin),
    .strobe(strobe)
  );

  gpio_dpath #(.NUM_PINS(NUM_PINS), .SYNC_DEPTH(2)) i_dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .wrData(wrData), .rdData(rdData),
    .pullupDis(pullupDis), .sleep(sleep), .padIn(padIn),
    .padOe(padOe), .padOut(padOut), .pullReq(pullReq)
  );
endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk #(
  parameter int NUM_PINS = 8
) (
  input logic                clk,
  input logic                rstN,
  input logic                wrDir,
  input logic                wrOut,
  input logic                wrPin,
  input logic                rdDir,
  input logic                rdOut,
  input logic                rdPin,
  input logic [NUM_PINS-1:0] wrData,
  input logic [NUM_PINS-1:0] rdData,
  input logic                pullupDis,
  input logic                sleep,
  input logic [NUM_PINS-1:0] padOe,
  input logic [NUM_PINS-1:0] padOut,
  input logic [NUM_PINS-1:0] pullReq
);
  // R2
  dir_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrDir |=> padOe == $past(wrData));
  // R3
  out_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrOut |=> padOut == $past(wrData));
  // R4
  toggle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrPin && !wrOut) |=> padOut == ($past(padOut) ^ $past(wrData)));
  // R6
  pull_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    pullReq == (~padOe & padOut & {NUM_PINS{~pullupDis}}));
  // R9
  idle_bus_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(rdDir || rdOut || rdPin) |-> rdData == '0);
  // R10
  out_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!wrOut && !wrPin) |=> $stable(padOut));
  // R10
  dir_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !wrDir |=> $stable(padOe));
  // R8
  sleep_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sleep && $past(sleep) && $past(sleep, 2) && rdPin && !rdDir && !rdOut) |-> rdData == '0);
endmodule

bind gpio_port_ctl gpio_port_chk #(.NUM_PINS(NUM_PINS)) i_chk (
  .clk(clk), .rstN(rstN), .wrDir(wrDir), .wrOut(wrOut), .wrPin(wrPin),
  .rdDir(rdDir), .rdOut(rdOut), .rdPin(rdPin), .wrData(wrData),
  .rdData(rdData), .pullupDis(pullupDis), .sleep(sleep),
  .padOe(padOe), .padOut(padOut), .pullReq(pullReq)
);

// File: tb/test_gpio_port_ctl.sv
`timescale 1ns/1ps
module test_gpio_port_ctl;
  localparam int N = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrDir = 0, wrOut = 0, wrPin = 0, rdDir = 0, rdOut = 0, rdPin = 0;
  logic [N-1:0] wrData = '0;
  logic [N-1:0] rdData;
  logic pullupDis = 0, sleep = 0;
  logic [N-1:0] padIn = '0;
  logic [N-1:0] padOe, padOut, pullReq;

  int total = 0;
  int bad = 0;
  bit finished = 0;
  logic [N-1:0] expDir = '0, expOut = '0;

  always #2.5 clk = ~clk;

  gpio_port_ctl #(.NUM_PINS(N)) i_gpio_port_ctl (
    .clk(clk), .rstN(rstN), .wrDir(wrDir), .wrOut(wrOut), .wrPin(wrPin),
    .rdDir(rdDir), .rdOut(rdOut), .rdPin(rdPin), .wrData(wrData),
    .rdData(rdData), .pullupDis(pullupDis), .sleep(sleep), .padIn(padIn),
    .padOe(padOe), .padOut(padOut), .pullReq(pullReq)
  );

  function automatic logic [N-1:0] pullExp(logic [N-1:0] d, logic [N-1:0] o, logic dis);
    return dis ? '0 : (~d & o);
  endfunction

  task automatic check(string req, logic [N-1:0] act, logic [N-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // 0=dir 1=out 2=pin
  task automatic doWrite(int kind, logic [N-1:0] d);
    @(negedge clk);
    wrData = d;
    wrDir = (kind == 0); wrOut = (kind == 1); wrPin = (kind == 2);
    @(negedge clk);
    wrDir = 0; wrOut = 0; wrPin = 0;
    if (kind == 0) expDir = d;
    else if (kind == 1) expOut = d;
    else expOut = expOut ^ d;
  endtask

  // samples at the current negedge, no clock edge inside
  task automatic doRead(logic d, logic o, logic p, output logic [N-1:0] v);
    rdDir = d; rdOut = o; rdPin = p;
    #1 v = rdData;
    rdDir = 0; rdOut = 0; rdPin = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [N-1:0] v, a, b;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 padOe", padOe, '0);
    check("R1 padOut", padOut, '0);
    doRead(0, 0, 1, v); check("R1 pin", v, '0);
    // R9 idle bus
    check("R9 idle", rdData, '0);

    // R2 / R10 direction
    doWrite(0, 8'hA5);
    check("R2 padOe", padOe, 8'hA5);
    check("R10 out kept", padOut, '0);
    doRead(1, 0, 0, v); check("R9 rdDir", v, 8'hA5);
    // R3
    doWrite(1, 8'h3C);
    check("R3 padOut", padOut, 8'h3C);
    check("R10 dir kept", padOe, 8'hA5);
    doRead(0, 1, 0, v); check("R3 rdOut", v, 8'h3C);
    // R4 toggle
    doWrite(2, 8'h0F);
    check("R4 toggle", padOut, 8'h33);
    doWrite(2, 8'h00);
    check("R4 zero toggle", padOut, 8'h33);
    // R5 collision
    @(negedge clk);
    wrData = 8'h96; wrOut = 1; wrPin = 1;
    @(negedge clk);
    wrOut = 0; wrPin = 0; expOut = 8'h96;
    check("R5 collision", padOut, 8'h96);
    // R9 OR of two reads
    doRead(1, 1, 0, v); check("R9 or", v, 8'hA5 | 8'h96);
    // R6 pull requests
    pullupDis = 0; #1 check("R6 pull", pullReq, pullExp(expDir, expOut, 0));
    pullupDis = 1; #1 check("R6 disabled", pullReq, '0);
    pullupDis = 0;

    // R7 latency window
    @(negedge clk); padIn = 8'h5A; sleep = 0;
    @(negedge clk); @(negedge clk);
    doRead(0, 0, 1, v); check("R7 settled", v, 8'h5A);
    padIn = 8'hC3;
    @(negedge clk);
    doRead(0, 0, 1, v); check("R7 one edge", v, 8'h5A);
    @(negedge clk);
    doRead(0, 0, 1, v); check("R7 two edges", v, 8'hC3);
    // R8 sleep
    sleep = 1;
    @(negedge clk);
    doRead(0, 0, 1, v); check("R8 sleep one edge", v, 8'hC3);
    @(negedge clk);
    doRead(0, 0, 1, v); check("R8 sleep zero", v, 8'h00);
    sleep = 0;
    @(negedge clk); @(negedge clk);
    doRead(0, 0, 1, v); check("R8 wake", v, 8'hC3);

    // random mix
    for (int i = 0; i < 300; i++) begin
      int op;
      op = $urandom % 4;
      a = N'($urandom);
      if (op < 3) doWrite(op, a);
      else begin
        @(negedge clk);
        b = N'($urandom);
        padIn = a; sleep = b[0];
        @(negedge clk); @(negedge clk);
        doRead(0, 0, 1, v); check(b[0] ? "R8 rand" : "R7 rand", v, b[0] ? '0 : a);
      end
      check("R2 rand", padOe, expDir);
      check("R3 rand", padOut, expOut);
      pullupDis = $urandom % 2;
      #1 check("R6 rand", pullReq, pullExp(expDir, expOut, pullupDis));
      doRead(1, 0, 0, v); check("R9 rand dir", v, expDir);
      doRead(0, 1, 0, v); check("R4 rand out", v, expOut);
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule